// File: doc/BRIEF.md
# JK-Entry Parallel-Access Shift Register

A synchronous register of `WIDTH` stages that either loads every stage from a parallel data bus or moves its contents one stage toward the highest index. The choice is made on each rising clock edge by an active-low load select.

In shift mode the lowest stage does not take a plain serial bit. It takes a J input and an active-low K input, so it can set, clear, toggle or keep its own previous value. Tying J and the active-low K together turns it into an ordinary serial data input.

An active-low master reset clears all stages at once, without waiting for the clock. A dedicated output always presents the inverse of the highest stage. The block fits wherever a small serial/parallel converter or a counter-like first stage is needed.

Top module: `jk_shift_reg`

## Requirements
- R1: With `load_n` low, a rising edge of `clk` copies `din` into `q` (bit i to stage i), and `j`/`k_n` have no effect on that edge.
- R2: With `load_n` high, a rising edge moves stage i into stage i+1 for every i from 0 to WIDTH-2.
- R3: In shift mode, `j`=1 with `k_n`=1 makes stage 0 become 1.
- R4: In shift mode, `j`=0 with `k_n`=0 makes stage 0 become 0.
- R5: In shift mode, `j`=1 with `k_n`=0 makes stage 0 become the inverse of its previous value.
- R6: In shift mode, `j`=0 with `k_n`=1 leaves stage 0 at its previous value.
- R7: While `rst_n` is low, `q` is all zeros. The clear takes effect without a clock edge and overrides load and shift.
- R8: `q_last_n` always equals the inverse of `q[WIDTH-1]`, so it is 1 during reset.
- R9: With `j` and `k_n` driven by the same bit, repeated shifts store that bit stream, newest bit in stage 0.
- R10: `q` changes only on a rising `clk` edge or on reset assertion. Input changes between edges leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous master clear, active low |
| load_n | input | 1 | 0: parallel load, 1: shift toward higher index |
| j | input | 1 | First-stage J input |
| k_n | input | 1 | First-stage K input, active low |
| din | input | WIDTH | Parallel data in |
| q | output | WIDTH | Stage outputs |
| q_last_n | output | 1 | Inverse of highest stage |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is parallel load and serial entry. The bench loads with `load_n` low while holding `j`/`k_n` at a toggle or set code that would alter stage 0. Any such change counts as a failure of load priority.

The second pair is the asynchronous clear and a pending load. The bench drops `rst_n` between edges and checks `q` before any edge. It then keeps clocking with `load_n` low and `din` all ones while reset is held, and judges that `q` stays zero until release. Only the first edge after release may load.

// File: rtl/jk_shift_reg.sv
module jk_shift_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             j,
  input  logic             k_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             q_last_n
);

  logic [WIDTH-1:0] stage;
  logic [WIDTH-1:0] nxt;
  logic             head;

  always_comb begin
    case ({j, k_n})
      2'b11:   head = 1'b1;
      2'b00:   head = 1'b0;
      2'b10:   head = ~stage[0];
      default: head = stage[0];
    endcase
  end

  assign nxt[0] = load_n ? head : din[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    assign nxt[i] = load_n ? stage[i-1] : din[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage <= '0;
    else        stage <= nxt;
  end

  assign q        = stage;
  assign q_last_n = ~stage[WIDTH-1];

endmodule

// File: rtl/jk_shift_reg_chk.sv
module jk_shift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_n,
  input logic             j,
  input logic             k_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             q_last_n
);

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> q == $past(din));

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> q[WIDTH-1:1] == $past(q[WIDTH-2:0]));

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && j && k_n) |=> q[0]);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !j && !k_n) |=> !q[0]);

  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && j && !k_n) |=> q[0] != $past(q[0]));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !j && k_n) |=> q[0] == $past(q[0]));

  p_reset_r7: assert property (@(posedge clk)
    !rst_n |-> (q == '0 && q_last_n));

endmodule

bind jk_shift_reg jk_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_n(load_n), .j(j), .k_n(k_n),
  .din(din), .q(q), .q_last_n(q_last_n)
);

// File: tb/jk_shift_reg_tb.sv
module jk_shift_reg_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         load_n = 1'b1;
  logic         j = 1'b0;
  logic         k_n = 1'b1;
  logic [W-1:0] din = '0;
  logic [W-1:0] q;
  logic         q_last_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  jk_shift_reg #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .j(j), .k_n(k_n),
    .din(din), .q(q), .q_last_n(q_last_n)
  );

  task automatic chk(input string req, input logic [W-1:0] exp);
    checks++;
    if (q !== exp || q_last_n !== ~exp[W-1]) begin
      errors++;
      $display("FAIL %s: q=%b q_last_n=%b expected q=%b q_last_n=%b",
               req, q, q_last_n, exp, ~exp[W-1]);
    end
  endtask

  task automatic edge_drive(input logic ld, input logic jj, input logic kk,
                            input logic [W-1:0] d);
    @(negedge clk);
    load_n = ld; j = jj; k_n = kk; din = d;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    #1 chk("R7 R8 reset state", 4'b0000);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_load;
    edge_drive(1'b0, 1'b1, 1'b0, 4'b1010);
    chk("R1 load ignores toggle code", 4'b1010);
    edge_drive(1'b0, 1'b1, 1'b1, 4'b0101);
    chk("R1 load ignores set code, R8", 4'b0101);
  endtask

  task automatic t_set_clear;
    edge_drive(1'b1, 1'b1, 1'b1, 4'b0000);
    chk("R2 R3 shift with set", 4'b1011);
    edge_drive(1'b1, 1'b0, 1'b0, 4'b1111);
    chk("R2 R4 shift with clear", 4'b0110);
  endtask

  task automatic t_toggle;
    edge_drive(1'b1, 1'b1, 1'b0, 4'b0000);
    chk("R5 toggle from 0", 4'b1101);
    edge_drive(1'b1, 1'b1, 1'b0, 4'b0000);
    chk("R5 toggle from 1", 4'b1010);
  endtask

  task automatic t_hold;
    edge_drive(1'b1, 1'b0, 1'b1, 4'b1111);
    chk("R6 hold of 0", 4'b0100);
    edge_drive(1'b0, 1'b0, 1'b0, 4'b0001);
    chk("R1 reload", 4'b0001);
    edge_drive(1'b1, 1'b0, 1'b1, 4'b0000);
    chk("R6 hold of 1", 4'b0011);
  endtask

  task automatic t_dmode;
    logic [3:0] bits;
    edge_drive(1'b0, 1'b0, 1'b0, 4'b0000);
    bits = 4'b1011;
    for (int i = 3; i >= 0; i--) edge_drive(1'b1, bits[i], bits[i], 4'b0000);
    chk("R9 tied J/K_n stream", 4'b1011);
  endtask

  task automatic t_between_edges;
    edge_drive(1'b0, 1'b0, 1'b1, 4'b0110);
    #2 din = 4'b1001; j = 1'b1; k_n = 1'b0;
    #1 chk("R10 no change between edges", 4'b0110);
    @(posedge clk); #1;
    chk("R1 R10 change at edge", 4'b1001);
  endtask

  task automatic t_reset_collide;
    edge_drive(1'b0, 1'b0, 1'b1, 4'b1111);
    chk("R1 load ones", 4'b1111);
    #2 rst_n = 1'b0;
    #1 chk("R7 async clear without edge", 4'b0000);
    @(posedge clk); #1;
    chk("R7 reset beats load", 4'b0000);
    @(posedge clk); #1;
    chk("R7 reset held", 4'b0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 first edge after release loads", 4'b1111);
  endtask

  initial begin
    t_reset;
    t_load;
    t_set_clear;
    t_toggle;
    t_hold;
    t_dmode;
    t_between_edges;
    t_reset_collide;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule